// File: doc/BRIEF.md
# SDI Receive Status Monitor

This block gathers receive-side link status for a small four-page status display. It counts timing-reference placement errors, where a start-of-active-video error and an end-of-active-video error count alike. It counts CRC errors separately, and it keeps an elapsed-seconds clock. All three run from the most recent press of an error-clear button. Both error counters and the clock stop at all-ones instead of wrapping. Error strobes are counted only while the receiver reports that it is locked to video.

A second debounced button steps a page selector through a fixed loop of four pages. On each step the block raises a one-cycle refresh flag so that a display driver can redraw. The page selector is a four-state machine with states `PG_TX_FMT` (page 0, transmit rate and format), `PG_TX_PID` (page 1, transmit payload identifier), `PG_RX_PID` (page 2, receive payload identifier) and `PG_RX_ERR` (page 3, placement, CRC and time counters). It has one transition, taken on a page press: `PG_TX_FMT`→`PG_TX_PID`→`PG_RX_PID`→`PG_RX_ERR`→`PG_TX_FMT`. Without a press it holds its state. All outputs are registered and change on the clock edge that samples the input.

Top module: `rx_status_monitor`

## Requirements
- R1: While the active-low reset `rst_n` is asserted and after its release, `page` is 0, `page_chg` is 0 and all three counters are 0.
- R2: Each cycle with `page_btn` high moves `page` to the next value in the loop 0→1→2→3→0 on the following edge. Code 0 is transmit format, 1 is transmit payload ID, 2 is receive payload ID and 3 is the counter page. With no press the page holds.
- R3: `page_chg` is high for exactly the one cycle after each `page_btn` cycle, which is the same cycle in which the new `page` value first appears. It is low otherwise.
- R4: In a cycle with `vid_active` high and `sav_err` or `eav_err` high, `place_cnt` rises by one. When both strobes are high in the same cycle it still rises by one only.
- R5: In a cycle with `vid_active` high and `crc_err` high, `crc_cnt` rises by one, independently of `place_cnt`.
- R6: When `vid_active` is low, `sav_err`, `eav_err` and `crc_err` leave both error counts unchanged.
- R7: Each cycle with `sec_tick` high raises `elapsed` by one, whatever the state of `vid_active`.
- R8: A cycle with `clr_btn` high sets `place_cnt`, `crc_cnt` and `elapsed` to 0 on the next edge. This takes precedence over any increment in the same cycle and leaves `page` untouched.
- R9: `place_cnt` and `crc_cnt` (ERR_W bits, 16 by default) stay at all-ones once reached instead of wrapping.
- R10: `elapsed` (TIME_W bits) stays at all-ones once reached instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sav_err | input | 1 | Start-of-active-video placement error strobe |
| eav_err | input | 1 | End-of-active-video placement error strobe |
| crc_err | input | 1 | CRC error strobe |
| vid_active | input | 1 | Receiver locked to video |
| sec_tick | input | 1 | One-cycle pulse once per second |
| page_btn | input | 1 | Debounced single-cycle page-step press |
| clr_btn | input | 1 | Debounced single-cycle error/time clear press |
| page | output | 2 | Current display page |
| page_chg | output | 1 | One-cycle refresh flag after a page step |
| place_cnt | output | ERR_W | Saturating placement error count |
| crc_cnt | output | ERR_W | Saturating CRC error count |
| elapsed | output | TIME_W | Saturating seconds since the last clear |

## Verification
The bench drives simultaneous start- and end-of-video errors. A design that treats them as two events would step the placement count by two. The bench asserts clear in the same cycle as error strobes and a tick, and a design that gave the increment priority would leave a count of one instead of zero. It holds the CRC and placement strobes, and separately the tick, high long enough to reach all-ones, so that a counter without saturation shows a wrap to zero. It also presses the page button across the 3→0 boundary and during a clear. A selector that skipped a state, failed to wrap, or was disturbed by the clear would show the wrong page number or a stray or missing refresh flag.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;
    typedef enum logic [1:0] {
        PG_TX_FMT = 2'd0,
        PG_TX_PID = 2'd1,
        PG_RX_PID = 2'd2,
        PG_RX_ERR = 2'd3
    } page_t;
endpackage

// File: rtl/rxmon_page_fsm.sv
module rxmon_page_fsm
    import rxmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [1:0] page,
    output logic       refresh
);
    page_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_TX_FMT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                PG_TX_FMT: state_d = PG_TX_PID;
                PG_TX_PID: state_d = PG_RX_PID;
                PG_RX_PID: state_d = PG_RX_ERR;
                PG_RX_ERR: state_d = PG_TX_FMT;
                default:   state_d = PG_TX_FMT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) refresh <= 1'b0;
        else        refresh <= step;
    end

    assign page = state_q;

    // R2
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (page == 2'($past(page) + 2'd1)));
    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(page));
    // R3
    refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> !$stable(page));
endmodule

// File: rtl/rxmon_sat_cnt.sv
module rxmon_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                q <= '0;
        else if (clr)              q <= '0;
        else if (inc && q != TOP)  q <= q + 1'b1;
    end

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q == TOP && !clr) |=> (q == TOP));
    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && q != TOP) |=> (q == $past(q) || q == $past(q) + 1'b1));
endmodule

// File: rtl/rx_status_monitor.sv
module rx_status_monitor #(
    parameter int ERR_W  = 16,
    parameter int TIME_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sav_err,
    input  logic              eav_err,
    input  logic              crc_err,
    input  logic              vid_active,
    input  logic              sec_tick,
    input  logic              page_btn,
    input  logic              clr_btn,
    output logic [1:0]        page,
    output logic              page_chg,
    output logic [ERR_W-1:0]  place_cnt,
    output logic [ERR_W-1:0]  crc_cnt,
    output logic [TIME_W-1:0] elapsed
);
    logic place_hit, crc_hit;

    assign place_hit = vid_active & (sav_err | eav_err);
    assign crc_hit   = vid_active & crc_err;

    rxmon_page_fsm u_page (
        .clk(clk), .rst_n(rst_n), .step(page_btn),
        .page(page), .refresh(page_chg)
    );

    rxmon_sat_cnt #(.W(ERR_W)) u_place (
        .clk(clk), .rst_n(rst_n), .clr(clr_btn), .inc(place_hit), .q(place_cnt)
    );

    rxmon_sat_cnt #(.W(ERR_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(clr_btn), .inc(crc_hit), .q(crc_cnt)
    );

    rxmon_sat_cnt #(.W(TIME_W)) u_time (
        .clk(clk), .rst_n(rst_n), .clr(clr_btn), .inc(sec_tick), .q(elapsed)
    );

    // R6
    idle_video_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vid_active && !clr_btn) |=> ($stable(place_cnt) && $stable(crc_cnt)));
    // R8
    clear_keeps_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_btn && !page_btn) |=> $stable(page));
endmodule

// File: tb/sim_rx_status_monitor.sv
module sim_rx_status_monitor;
    localparam int EW = 16;
    localparam int TW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sav_err = 0, eav_err = 0, crc_err = 0, vid_active = 0;
    logic sec_tick = 0, page_btn = 0, clr_btn = 0;
    logic [1:0] page;
    logic page_chg;
    logic [EW-1:0] place_cnt, crc_cnt;
    logic [TW-1:0] elapsed;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int m_page = 0, m_chg = 0, m_place = 0, m_crc = 0, m_time = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_status_monitor #(.ERR_W(EW), .TIME_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .sav_err(sav_err), .eav_err(eav_err),
        .crc_err(crc_err), .vid_active(vid_active), .sec_tick(sec_tick),
        .page_btn(page_btn), .clr_btn(clr_btn), .page(page), .page_chg(page_chg),
        .place_cnt(place_cnt), .crc_cnt(crc_cnt), .elapsed(elapsed)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_page = 0; m_chg = 0; m_place = 0; m_crc = 0; m_time = 0;
        end else begin
            m_chg = page_btn;
            if (page_btn) m_page = (m_page + 1) % 4;
            if (clr_btn) begin
                m_place = 0; m_crc = 0; m_time = 0;
            end else begin
                if (vid_active && (sav_err || eav_err) && m_place < (1 << EW) - 1) m_place++;
                if (vid_active && crc_err && m_crc < (1 << EW) - 1) m_crc++;
                if (sec_tick && m_time < (1 << TW) - 1) m_time++;
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check("R2 page", page, m_page);
            check("R3 page_chg", page_chg, m_chg);
            check("R4 place_cnt", place_cnt, m_place);
            check("R5 crc_cnt", crc_cnt, m_crc);
            check("R7 elapsed", elapsed, m_time);
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic idle_inputs();
        sav_err = 0; eav_err = 0; crc_err = 0; sec_tick = 0; page_btn = 0; clr_btn = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        // R1 values held in reset
        check("R1 page", page, 0);
        check("R1 place", place_cnt, 0);
        rst_n = 1'b1;
        step();
        check("R1 page_chg", page_chg, 0);
        check("R1 elapsed", elapsed, 0);
        check("R1 crc", crc_cnt, 0);

        // R2 / R3: five presses cross the 3->0 wrap
        for (int i = 1; i <= 5; i++) begin
            page_btn = 1; step(); page_btn = 0;
            check("R2 page step", page, i % 4);
            check("R3 flag set", page_chg, 1);
            step();
            check("R3 flag drop", page_chg, 0);
        end

        // R4: both strobes in one cycle count once
        vid_active = 1; sav_err = 1; eav_err = 1; step(); idle_inputs();
        check("R4 dual strobe", place_cnt, 1);
        sav_err = 1; step(); idle_inputs();
        eav_err = 1; step(); idle_inputs();
        check("R4 single strobes", place_cnt, 3);
        // R5
        crc_err = 1; step(); idle_inputs();
        check("R5 crc", crc_cnt, 1);
        // R6: strobes ignored without video
        vid_active = 0; sav_err = 1; eav_err = 1; crc_err = 1; step(); idle_inputs();
        check("R6 place ignored", place_cnt, 3);
        check("R6 crc ignored", crc_cnt, 1);
        // R7: ticks counted without video
        repeat (3) begin sec_tick = 1; step(); end
        idle_inputs();
        check("R7 ticks", elapsed, 3);
        // R8: clear beats simultaneous increments, page untouched
        vid_active = 1; sav_err = 1; crc_err = 1; sec_tick = 1; clr_btn = 1; step(); idle_inputs();
        check("R8 place cleared", place_cnt, 0);
        check("R8 crc cleared", crc_cnt, 0);
        check("R8 time cleared", elapsed, 0);
        check("R8 page kept", page, 1);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            vid_active = ($urandom_range(0, 7) != 0);
            sav_err    = ($urandom_range(0, 3) == 0);
            eav_err    = ($urandom_range(0, 3) == 0);
            crc_err    = ($urandom_range(0, 4) == 0);
            sec_tick   = ($urandom_range(0, 5) == 0);
            page_btn   = ($urandom_range(0, 9) == 0);
            clr_btn    = ($urandom_range(0, 199) == 0);
            step();
        end
        idle_inputs();
        clr_btn = 1; step(); idle_inputs();

        // R9: error counters saturate
        vid_active = 1; sav_err = 1; crc_err = 1;
        repeat ((1 << EW) + 4) step();
        idle_inputs();
        check("R9 place saturated", place_cnt, (1 << EW) - 1);
        check("R9 crc saturated", crc_cnt, (1 << EW) - 1);

        // R10: elapsed saturates
        sec_tick = 1;
        repeat ((1 << TW) + 4) step();
        idle_inputs();
        check("R10 elapsed saturated", elapsed, (1 << TW) - 1);
        clr_btn = 1; step(); idle_inputs();
        check("R8 clear after saturation", place_cnt, 0);
        step();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule